// File: doc/BRIEF.md
# Multiply-Accumulate Unit with 64-bit Accumulator

This unit sits next to a 32-bit integer datapath. It keeps a 64-bit accumulator as a high word and a low word, and on each strobed operation it either loads a full-width product or adds/subtracts a full-width product to/from the accumulator. Signed forms extend their operands by sign and report signed overflow. Unsigned forms extend by zeros and report carry or borrow. A second operand can come from a 16-bit immediate. The result flags feed a range-exception request that is only raised while the overflow-exception enable is set.

The accumulator halves are visible on output ports. A synchronous clear zeroes them, so software or a testbench can bring the accumulator to a known start value. Writeback to a register file, instruction decode and exception vectoring belong to the surrounding core.

Top module: `mac_acc_unit`

## Requirements
- R1: After reset, acc_hi_o, acc_lo_o, ov_o, cy_o and range_exc_o are all 0.
- R2: Operation code 0 (signed load-multiply) writes the product of the sign-extended opa_i and opb_i to {acc_hi_o, acc_lo_o}, with the upper 32 bits in acc_hi_o. The new value is visible after the next rising clock edge.
- R3: Operation code 1 (unsigned load-multiply) writes the product of the zero-extended operands to the accumulator.
- R4: Operation code 2 (signed accumulate) adds the signed product to the accumulator. ov_o becomes 1 exactly when this signed 64-bit addition overflows.
- R5: Operation code 3 (unsigned accumulate) adds the unsigned product. cy_o becomes the carry out of the 64-bit addition.
- R6: Operation code 4 (signed subtract) stores the accumulator minus the signed product. ov_o becomes the signed 64-bit subtraction overflow.
- R7: Operation code 5 (unsigned subtract) stores the accumulator minus the unsigned product. cy_o becomes 1 exactly when the accumulator is below the product (borrow).
- R8: Operation code 6 (immediate accumulate) multiplies the sign-extended opa_i by the sign-extended 16-bit imm_i, then accumulates and sets ov_o as R4 does.
- R9: range_exc_o is 1 for the one cycle after an accepted accumulate/subtract operation, exactly when that operation's flag (ov_o for codes 2, 4, 6; cy_o for codes 3, 5) is 1 and ove_i was 1. Operation codes 0 and 1 never raise it.
- R10: A flag that an operation does not produce keeps its value. Codes 0 and 1 change neither flag, signed forms leave cy_o, and unsigned forms leave ov_o.
- R11: With valid_i low, or with the reserved operation code 7, the accumulator and both flags keep their values and range_exc_o is 0.
- R12: clr_i zeroes the accumulator on the next edge and takes priority over a simultaneous valid_i. The strobed operation is then dropped, and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous accumulator clear |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0..6, 7 reserved) |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate operand for code 6 |
| ove_i | input | 1 | Overflow-exception enable |
| acc_hi_o | output | 32 | Accumulator upper word |
| acc_lo_o | output | 32 | Accumulator lower word |
| ov_o | output | 1 | Signed overflow flag |
| cy_o | output | 1 | Carry / borrow flag |
| range_exc_o | output | 1 | Range-exception request (one-cycle pulse) |

## Verification
The assertions check these rules on every cycle: the flag-retention rules for the load-multiply and signed/unsigned forms, the accumulator holding while idle, the effect of a clear, and the condition that a range exception needs both a set flag and the enable. The bench's reference model is needed to show the arithmetic itself: the 64-bit products under sign and zero extension, the immediate sign extension, and the exact overflow, carry and borrow boundaries. Directed sequences push the accumulator to the positive and negative signed limits and to the unsigned wrap.

// File: rtl/mac_acc_pkg.sv
package mac_acc_pkg;
  typedef enum logic [2:0] {
    OP_MULS = 3'd0,
    OP_MULU = 3'd1,
    OP_MACS = 3'd2,
    OP_MACU = 3'd3,
    OP_MSBS = 3'd4,
    OP_MSBU = 3'd5,
    OP_MACI = 3'd6,
    OP_RSVD = 3'd7
  } mac_op_e;

  typedef struct packed {
    logic legal;
    logic is_mul;
    logic is_sub;
    logic sgn;
    logic use_imm;
  } mac_ctl_t;

  function automatic mac_ctl_t mac_decode(input logic [2:0] op);
    mac_ctl_t c;
    c = '0;
    case (op)
      OP_MULS: c = '{legal: 1'b1, is_mul: 1'b1, is_sub: 1'b0, sgn: 1'b1, use_imm: 1'b0};
      OP_MULU: c = '{legal: 1'b1, is_mul: 1'b1, is_sub: 1'b0, sgn: 1'b0, use_imm: 1'b0};
      OP_MACS: c = '{legal: 1'b1, is_mul: 1'b0, is_sub: 1'b0, sgn: 1'b1, use_imm: 1'b0};
      OP_MACU: c = '{legal: 1'b1, is_mul: 1'b0, is_sub: 1'b0, sgn: 1'b0, use_imm: 1'b0};
      OP_MSBS: c = '{legal: 1'b1, is_mul: 1'b0, is_sub: 1'b1, sgn: 1'b1, use_imm: 1'b0};
      OP_MSBU: c = '{legal: 1'b1, is_mul: 1'b0, is_sub: 1'b1, sgn: 1'b0, use_imm: 1'b0};
      OP_MACI: c = '{legal: 1'b1, is_mul: 1'b0, is_sub: 1'b0, sgn: 1'b1, use_imm: 1'b1};
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mac_operand_ext.sv
module mac_operand_ext #(
  parameter int DW = 32,
  parameter int IW = 16,
  localparam int AW = 2 * DW
) (
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [IW-1:0] imm_i,
  input  logic          sgn_i,
  input  logic          use_imm_i,
  output logic [AW-1:0] ext_a_o,
  output logic [AW-1:0] ext_b_o
);
  logic [AW-1:0] b_reg_ext;
  logic [AW-1:0] imm_ext;

  always_comb begin
    ext_a_o   = sgn_i ? {{DW{opa_i[DW-1]}}, opa_i} : {{DW{1'b0}}, opa_i};
    b_reg_ext = sgn_i ? {{DW{opb_i[DW-1]}}, opb_i} : {{DW{1'b0}}, opb_i};
    imm_ext   = {{(AW-IW){imm_i[IW-1]}}, imm_i};
    ext_b_o   = use_imm_i ? imm_ext : b_reg_ext;
  end
endmodule

// File: rtl/mac_wide_mult.sv
module mac_wide_mult #(
  parameter int DW = 32,
  localparam int AW = 2 * DW
) (
  input  logic [AW-1:0] ext_a_i,
  input  logic [AW-1:0] ext_b_i,
  output logic [AW-1:0] prod_o
);
  always_comb begin
    prod_o = ext_a_i * ext_b_i;
  end
endmodule

// File: rtl/mac_acc_addsub.sv
module mac_acc_addsub #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] acc_i,
  input  logic [AW-1:0] prod_i,
  input  logic          sub_i,
  output logic [AW-1:0] res_o,
  output logic          carry_o,
  output logic          ovf_o
);
  logic [AW:0] wide;

  always_comb begin
    if (sub_i) begin
      wide  = {1'b0, acc_i} - {1'b0, prod_i};
    end else begin
      wide  = {1'b0, acc_i} + {1'b0, prod_i};
    end
    res_o   = wide[AW-1:0];
    carry_o = wide[AW];
    if (sub_i) begin
      ovf_o = (acc_i[AW-1] != prod_i[AW-1]) && (res_o[AW-1] != acc_i[AW-1]);
    end else begin
      ovf_o = (acc_i[AW-1] == prod_i[AW-1]) && (res_o[AW-1] != acc_i[AW-1]);
    end
  end
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_acc_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [IW-1:0] imm_i,
  input  logic          ove_i,
  output logic [DW-1:0] acc_hi_o,
  output logic [DW-1:0] acc_lo_o,
  output logic          ov_o,
  output logic          cy_o,
  output logic          range_exc_o
);
  localparam int AW = 2 * DW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mac_ctl_t      ctl;
  logic [AW-1:0] ext_a, ext_b, prod, as_res, acc_q, acc_d;
  logic          as_cy, as_ov;
  logic          ov_q, ov_d, cy_q, cy_d, exc_q, exc_d;
  logic          acc_en, ov_en, cy_en;

  assign ctl = mac_decode(op_i);

  mac_operand_ext #(.DW(DW), .IW(IW)) u_ext (
    .opa_i     (opa_i),
    .opb_i     (opb_i),
    .imm_i     (imm_i),
    .sgn_i     (ctl.sgn),
    .use_imm_i (ctl.use_imm),
    .ext_a_o   (ext_a),
    .ext_b_o   (ext_b)
  );

  mac_wide_mult #(.DW(DW)) u_mult (
    .ext_a_i (ext_a),
    .ext_b_i (ext_b),
    .prod_o  (prod)
  );

  mac_acc_addsub #(.AW(AW)) u_addsub (
    .acc_i   (acc_q),
    .prod_i  (prod),
    .sub_i   (ctl.is_sub),
    .res_o   (as_res),
    .carry_o (as_cy),
    .ovf_o   (as_ov)
  );

  // next-state logic
  always_comb begin
    acc_d  = acc_q;
    ov_d   = ov_q;
    cy_d   = cy_q;
    exc_d  = 1'b0;
    acc_en = 1'b0;
    ov_en  = 1'b0;
    cy_en  = 1'b0;
    if (clr_i) begin
      acc_d  = '0;
      acc_en = 1'b1;
    end else if (valid_i && ctl.legal) begin
      acc_en = 1'b1;
      acc_d  = ctl.is_mul ? prod : as_res;
      if (!ctl.is_mul) begin
        if (ctl.sgn) begin
          ov_en = 1'b1;
          ov_d  = as_ov;
          exc_d = as_ov & ove_i;
        end else begin
          cy_en = 1'b1;
          cy_d  = as_cy;
          exc_d = as_cy & ove_i;
        end
      end
    end
  end

  // state registers with explicit enables
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ov_q <= 1'b0;
    end else if (ov_en) begin
      ov_q <= ov_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cy_q <= 1'b0;
    end else if (cy_en) begin
      cy_q <= cy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      exc_q <= 1'b0;
    end else begin
      exc_q <= exc_d;
    end
  end

  assign acc_hi_o    = acc_q[AW-1:DW];
  assign acc_lo_o    = acc_q[DW-1:0];
  assign ov_o        = ov_q;
  assign cy_o        = cy_q;
  assign range_exc_o = exc_q;
endmodule

// File: rtl/mac_acc_unit_chk.sv
module mac_acc_unit_chk
  import mac_acc_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          clr_i,
  input logic          valid_i,
  input logic [2:0]    op_i,
  input logic          ove_i,
  input logic [DW-1:0] acc_hi_o,
  input logic [DW-1:0] acc_lo_o,
  input logic          ov_o,
  input logic          cy_o,
  input logic          range_exc_o
);
  logic live;
  assign live = valid_i && !clr_i;

  // R10: load-multiply forms touch neither flag
  a_r10_mul_keeps_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live && (op_i == OP_MULS || op_i == OP_MULU) |=> $stable(ov_o) && $stable(cy_o));

  // R10: signed forms leave carry alone
  a_r10_signed_keeps_cy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live && (op_i == OP_MACS || op_i == OP_MSBS || op_i == OP_MACI) |=> $stable(cy_o));

  // R10: unsigned forms leave overflow alone
  a_r10_unsigned_keeps_ov: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live && (op_i == OP_MACU || op_i == OP_MSBU) |=> $stable(ov_o));

  // R11: idle or reserved code holds all state
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clr_i && (!valid_i || op_i == OP_RSVD) |=>
      $stable(acc_hi_o) && $stable(acc_lo_o) && $stable(ov_o) && $stable(cy_o) && !range_exc_o);

  // R12: clear zeroes the accumulator and keeps the flags
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_i |=> acc_hi_o == '0 && acc_lo_o == '0 && $stable(ov_o) && $stable(cy_o) && !range_exc_o);

  // R9: an exception needs the enable, an accepted non-load op, and a set flag
  a_r9_exc_needs_enable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(range_exc_o) |-> $past(ove_i) && $past(live) &&
      $past(op_i) != OP_MULS && $past(op_i) != OP_MULU);

  a_r9_exc_needs_flag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    range_exc_o |-> ov_o || cy_o);
endmodule

bind mac_acc_unit mac_acc_unit_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .clr_i       (clr_i),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .ove_i       (ove_i),
  .acc_hi_o    (acc_hi_o),
  .acc_lo_o    (acc_lo_o),
  .ov_o        (ov_o),
  .cy_o        (cy_o),
  .range_exc_o (range_exc_o)
);

// File: tb/mac_acc_unit_bench.sv
module mac_acc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_i, valid_i, ove_i;
  logic [2:0]  op_i;
  logic [31:0] opa_i, opb_i;
  logic [15:0] imm_i;
  logic [31:0] acc_hi_o, acc_lo_o;
  logic        ov_o, cy_o, range_exc_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_acc;
  logic        m_ov, m_cy, m_exc;

  always #4 clk = ~clk;

  mac_acc_unit u_mac_acc_unit (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .valid_i(valid_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i), .ove_i(ove_i),
    .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o), .ov_o(ov_o), .cy_o(cy_o),
    .range_exc_o(range_exc_o)
  );

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R11";
    endcase
  endfunction

  // reference model: signed overflow via 65-bit sign-extended arithmetic
  task automatic model(input logic c, input logic v, input logic [2:0] op,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic en);
    longint p;
    logic [64:0] s65;
    logic [64:0] u65;
    m_exc = 1'b0;
    if (c) begin
      m_acc = 64'd0;
    end else if (v && op != 3'd7) begin
      case (op)
        3'd0, 3'd2, 3'd4: p = longint'($signed(a)) * longint'($signed(b));
        3'd6:             p = longint'($signed(a)) * longint'($signed(im));
        default:          p = longint'({32'd0, a}) * longint'({32'd0, b});
      endcase
      case (op)
        3'd0, 3'd1: m_acc = p;
        3'd2, 3'd6: begin
          s65 = {m_acc[63], m_acc} + {p[63], p};
          m_acc = s65[63:0];
          m_ov = s65[64] != s65[63];
          m_exc = m_ov & en;
        end
        3'd4: begin
          s65 = {m_acc[63], m_acc} - {p[63], p};
          m_acc = s65[63:0];
          m_ov = s65[64] != s65[63];
          m_exc = m_ov & en;
        end
        3'd3: begin
          u65 = {1'b0, m_acc} + {1'b0, p};
          m_acc = u65[63:0];
          m_cy = u65[64];
          m_exc = m_cy & en;
        end
        default: begin
          m_cy = m_acc < p;
          m_acc = m_acc - p;
          m_exc = m_cy & en;
        end
      endcase
    end
  endtask

  task automatic step(input logic c, input logic v, input logic [2:0] op,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] im, input logic en, input string req);
    clr_i = c; valid_i = v; op_i = op; opa_i = a; opb_i = b; imm_i = im; ove_i = en;
    model(c, v, op, a, b, im, en);
    @(negedge clk);
    chk({req, " acc"}, {acc_hi_o, acc_lo_o}, m_acc);
    chk({req, " ov"}, {63'd0, ov_o}, {63'd0, m_ov});
    chk({req, " cy"}, {63'd0, cy_o}, {63'd0, m_cy});
    chk({"R9 exc ", req}, {63'd0, range_exc_o}, {63'd0, m_exc});
  endtask

  initial begin
    process::self().srandom(32'd7531);
    rst_n = 1'b0; clr_i = 0; valid_i = 0; op_i = 0; opa_i = 0; opb_i = 0; imm_i = 0; ove_i = 0;
    m_acc = 0; m_ov = 0; m_cy = 0; m_exc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 acc", {acc_hi_o, acc_lo_o}, 64'd0);
    chk("R1 flags", {61'd0, ov_o, cy_o, range_exc_o}, 64'd0);

    // R2 / R3 load-multiply with explicit values
    step(0, 1, 3'd0, 32'hFFFF_FFFE, 32'h0000_0003, 0, 1, "R2");
    chk("R2 literal", {acc_hi_o, acc_lo_o}, 64'hFFFF_FFFF_FFFF_FFFA);
    step(0, 1, 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R3");
    chk("R3 literal", {acc_hi_o, acc_lo_o}, 64'hFFFF_FFFE_0000_0001);
    // R5 carry out, exception enabled
    step(0, 1, 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R5");
    chk("R5 carry", {63'd0, cy_o}, 64'd1);
    chk("R9 carry exc", {63'd0, range_exc_o}, 64'd1);
    // R10 load-multiply keeps carry
    step(0, 1, 3'd0, 32'h8000_0000, 32'h8000_0000, 0, 1, "R10");
    chk("R10 cy kept", {63'd0, cy_o}, 64'd1);
    // R4 signed overflow at +2^63, enable off
    step(0, 1, 3'd2, 32'h8000_0000, 32'h8000_0000, 0, 0, "R4");
    chk("R4 ov", {63'd0, ov_o}, 64'd1);
    chk("R9 no exc when disabled", {63'd0, range_exc_o}, 64'd0);
    // R12 clear beats valid, flags kept
    step(1, 1, 3'd2, 32'h1, 32'h1, 0, 1, "R12");
    chk("R12 zero", {acc_hi_o, acc_lo_o}, 64'd0);
    chk("R12 flags kept", {62'd0, ov_o, cy_o}, 64'd3);
    // R6 signed subtract to -2^63 then overflow
    step(0, 1, 3'd4, 32'h8000_0000, 32'h8000_0000, 0, 1, "R6");
    step(0, 1, 3'd4, 32'h8000_0000, 32'h8000_0000, 0, 1, "R6");
    chk("R6 at limit", {acc_hi_o, acc_lo_o}, 64'h8000_0000_0000_0000);
    step(0, 1, 3'd4, 32'h0000_0001, 32'h0000_0001, 0, 1, "R6");
    chk("R6 ov", {63'd0, ov_o}, 64'd1);
    // R7 borrow from zero
    step(1, 0, 3'd0, 0, 0, 0, 0, "R12");
    step(0, 1, 3'd5, 32'h0000_0002, 32'h0000_0003, 0, 1, "R7");
    chk("R7 borrow", {63'd0, cy_o}, 64'd1);
    chk("R7 value", {acc_hi_o, acc_lo_o}, 64'hFFFF_FFFF_FFFF_FFFA);
    // R8 negative immediate
    step(1, 0, 3'd0, 0, 0, 0, 0, "R12");
    step(0, 1, 3'd6, 32'h0000_0010, 32'hDEAD_BEEF, 16'hFFFE, 1, "R8");
    chk("R8 value", {acc_hi_o, acc_lo_o}, 64'hFFFF_FFFF_FFFF_FFE0);
    // R11 idle and reserved code
    step(0, 0, 3'd2, 32'h1234, 32'h5678, 0, 1, "R11");
    step(0, 1, 3'd7, 32'h1234, 32'h5678, 0, 1, "R11");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      logic [2:0]  op;
      a  = ($urandom_range(0, 3) == 0) ? {$urandom_range(0, 1) ? 1'b1 : 1'b0, 31'h0} : $urandom;
      b  = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      op = 3'($urandom_range(0, 7));
      step($urandom_range(0, 19) == 0, $urandom_range(0, 4) != 0, op, a, b,
           16'($urandom), 1'($urandom), tag_of(op));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule